// File: doc/BRIEF.md
# Match-Driven Single-Edge PWM Counter

This block is a free-running up-counter with a prescaler, four compare registers and three compare outputs. A programmable selector names one compare register as the cycle-length register: when the counter, on one of its increments, sits at that value, it returns to zero. In PWM mode a channel's output rises when the counter reaches the channel's compare value and falls again when the counter returns to zero. A channel not in PWM mode drives a static level taken from a software-written bit.

The counter advances only while the clock-enable input is high. The prescaler counts those enabled cycles and lets the counter step once each time it wraps. Counter and prescaler can also be forced to zero by a chosen edge on one of two asynchronous capture inputs. Software reaches all state through a flat register port: a write strobe with address and data, and a combinational read of the addressed register.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset every register reads 0 and all three outputs are low.
- R2: With prescale value P (address 0) the counter (address 2) steps once every P+1 cycles in which cnt_en is high; the prescaler count (address 1) restarts at 0 on each step. With cnt_en low neither count changes.
- R3: Address 3 bits 1:0 select which compare register (addresses 4 to 7 for compare 0 to 3) is the cycle length; a counter step taken while the counter equals that value loads 0 instead of incrementing.
- R4: For a channel i in PWM mode (address 8, bit i set), a counter step whose new value equals compare register i drives output i high.
- R5: A counter step that returns the counter to 0 drives every PWM output low, unless R6 applies.
- R6: A PWM channel whose compare value is 0 is set by the same step that clears it; set wins and the output stays high.
- R7: A PWM channel whose compare value is above the cycle length never goes high.
- R8: A channel with its bit at address 8 clear drives the level of bit i at address 9 on output i.
- R9: Address 10 bit 4 enables capture clearing; bits 7:5 select the edge: 0 rising on cap_in[0], 1 falling on cap_in[0], 2 rising on cap_in[1], 3 falling on cap_in[1]. The selected edge zeroes the counter and prescaler within four cycles after the input changes.
- R10: Codes 4 to 7, or bit 4 clear, leave the counter untouched for any capture edge.
- R11: Register bits with no function read 0 and ignore writes: address 8 and 9 read at most 0x0007, address 10 at most 0x00F0, address 3 at most 0x0003.
- R12: A capture clear also drives every PWM output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Clock enable for the prescaler and counter |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| cap_in | input | 2 | Asynchronous capture inputs |
| mat_out | output | 3 | Compare outputs |

## Verification
Random configurations vary the prescale, the cycle-length selector, all four compare values and the mode and static bits, while cnt_en toggles at random; the outputs are compared each cycle against a bench model, which separates a correct set/clear order from an off-by-one in the step or wrap. Directed cases pin the compare-at-zero case, where set must beat clear, and the compare-beyond-cycle case, where the output must stay low. Each capture edge code is tried against both polarities on both inputs, so a wrong decode or a missing synchronizer stage shows as a clear on the wrong edge or none at all.

// File: rtl/pwm_match_timer.sv
module pwm_match_timer #(
  parameter int W   = 16,
  parameter int NCH = 3,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [1:0]    cap_in,
  output logic [NCH-1:0] mat_out
);
  localparam int NM    = NCH + 1;
  localparam int SW    = $clog2(NM);
  localparam int A_PR  = 0;
  localparam int A_PC  = 1;
  localparam int A_TC  = 2;
  localparam int A_SEL = 3;
  localparam int A_M0  = 4;
  localparam int A_PEN = A_M0 + NM;
  localparam int A_EXT = A_PEN + 1;
  localparam int A_CLR = A_PEN + 2;

  logic [W-1:0]   pr_q, pc_q, tc_q;
  logic [W-1:0]   m_q [NM];
  logic [SW-1:0]  psel_q;
  logic [NCH-1:0] pen_q, ext_q, pwm_q;
  logic           cen_q;
  logic [2:0]     csel_q;
  logic [1:0]     s1_q, s2_q, s3_q;

  logic [W-1:0] period, tc_nxt;
  logic         tick, clr_hit, edge_hit;
  logic [1:0]   rise, fall;

  assign period = m_q[psel_q];
  assign tick   = cnt_en && (pc_q >= pr_q);
  assign tc_nxt = (tc_q == period) ? '0 : tc_q + 1'b1;
  assign rise   = s2_q & ~s3_q;
  assign fall   = ~s2_q & s3_q;

  always_comb begin
    case (csel_q)
      3'd0:    edge_hit = rise[0];
      3'd1:    edge_hit = fall[0];
      3'd2:    edge_hit = rise[1];
      3'd3:    edge_hit = fall[1];
      default: edge_hit = 1'b0;
    endcase
  end
  assign clr_hit = cen_q && edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= cap_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_q   <= '0;
      psel_q <= '0;
      pen_q  <= '0;
      ext_q  <= '0;
      cen_q  <= 1'b0;
      csel_q <= '0;
      for (int i = 0; i < NM; i++) m_q[i] <= '0;
    end else if (wr_en) begin
      if (addr == AW'(A_PR))  pr_q   <= wdata;
      if (addr == AW'(A_SEL)) psel_q <= wdata[SW-1:0];
      if (addr == AW'(A_PEN)) pen_q  <= wdata[NCH-1:0];
      if (addr == AW'(A_EXT)) ext_q  <= wdata[NCH-1:0];
      if (addr == AW'(A_CLR)) begin
        cen_q  <= wdata[4];
        csel_q <= wdata[7:5];
      end
      for (int i = 0; i < NM; i++)
        if (addr == AW'(A_M0 + i)) m_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      tc_q  <= '0;
      pwm_q <= '0;
    end else if (clr_hit) begin
      pc_q  <= '0;
      tc_q  <= '0;
      pwm_q <= '0;
    end else begin
      if (cnt_en) pc_q <= tick ? '0 : pc_q + 1'b1;
      if (tick) begin
        tc_q <= tc_nxt;
        for (int i = 0; i < NCH; i++)
          pwm_q[i] <= (tc_nxt == m_q[i]) || (pwm_q[i] && (tc_nxt != '0));
      end
      if (wr_en && addr == AW'(A_PC)) pc_q <= wdata;
      if (wr_en && addr == AW'(A_TC)) tc_q <= wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_out
      assign mat_out[g] = pen_q[g] ? pwm_q[g] : ext_q[g];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_PR)) rdata = pr_q;
    if (addr == AW'(A_PC)) rdata = pc_q;
    if (addr == AW'(A_TC)) rdata = tc_q;
    if (addr == AW'(A_SEL)) rdata[SW-1:0] = psel_q;
    if (addr == AW'(A_PEN)) rdata[NCH-1:0] = pen_q;
    if (addr == AW'(A_EXT)) rdata[NCH-1:0] = ext_q;
    if (addr == AW'(A_CLR)) begin
      rdata[4]   = cen_q;
      rdata[7:5] = csel_q;
    end
    for (int i = 0; i < NM; i++)
      if (addr == AW'(A_M0 + i)) rdata = m_q[i];
  end
endmodule

module pwm_match_timer_chk #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cnt_en,
  input logic           wr_en,
  input logic [W-1:0]   pr,
  input logic [W-1:0]   pc,
  input logic [W-1:0]   tc,
  input logic [W-1:0]   period,
  input logic           clr,
  input logic [NCH-1:0] pwm
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en && !clr) |=> ($stable(tc) && $stable(pc)));

  a_r2_pre_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && (pc < pr) && !clr && !wr_en) |=> (pc == $past(pc) + 1'b1));

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && (pc >= pr) && (tc == period) && !clr && !wr_en) |=> (tc == '0));

  a_r9_cap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tc == '0 && pc == '0));

  a_r12_pwm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pwm == '0));
endmodule

bind pwm_match_timer pwm_match_timer_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
  .pr(pr_q), .pc(pc_q), .tc(tc_q), .period(period),
  .clr(clr_hit), .pwm(pwm_q)
);

// File: tb/sim_pwm_match_timer.sv
module sim_pwm_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  cap_in = '0;
  logic [2:0]  mat_out;

  int checks = 0;
  int failures = 0;

  pwm_match_timer u0 (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .mat_out(mat_out));

  always #5 clk = ~clk;

  logic        model_on = 1'b0;
  logic [15:0] pr_c;
  logic [15:0] mm [4];
  logic [1:0]  psel_c;
  logic [2:0]  pen_c, ext_c;
  logic [15:0] pc_m, tc_m, nxt_m;
  logic [2:0]  pq_m;

  always @(posedge clk) begin
    if (!model_on) begin
      pc_m = '0; tc_m = '0; pq_m = '0;
    end else if (cnt_en) begin
      if (pc_m >= pr_c) begin
        pc_m = '0;
        nxt_m = (tc_m == mm[psel_c]) ? 16'd0 : tc_m + 16'd1;
        for (int i = 0; i < 3; i++)
          pq_m[i] = (nxt_m == mm[i]) ? 1'b1 : ((nxt_m == 16'd0) ? 1'b0 : pq_m[i]);
        tc_m = nxt_m;
      end else begin
        pc_m = pc_m + 16'd1;
      end
    end
  end

  function automatic logic [2:0] exp_out(input logic [2:0] pen, input logic [2:0] pq,
                                         input logic [2:0] ext);
    return (pen & pq) | (~pen & ext);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 4'(a); wdata = 16'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0; cap_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd12345));
    do_reset();

    for (int a = 0; a < 11; a++) begin
      rd(a, v);
      chk(v == 16'd0, "R1 reset register", int'(v), 0);
    end
    chk(mat_out == 3'd0, "R1 reset outputs", int'(mat_out), 0);

    wr(8, 16'hFFFF); rd(8, v); chk(v == 16'h0007, "R11 mode reg", int'(v), 7);
    wr(9, 16'hFFFF); rd(9, v); chk(v == 16'h0007, "R11 static reg", int'(v), 7);
    wr(10, 16'hFFFF); rd(10, v); chk(v == 16'h00F0, "R11 clear ctl", int'(v), 'hF0);
    wr(3, 16'hFFFF); rd(3, v); chk(v == 16'h0003, "R11 selector", int'(v), 3);

    do_reset();
    wr(9, 5); wait_n(1);
    chk(mat_out == 3'b101, "R8 static level", int'(mat_out), 5);
    wr(9, 2); wait_n(1);
    chk(mat_out == 3'b010, "R8 static level b", int'(mat_out), 2);

    do_reset();
    wr(4, 100); wr(0, 3);
    @(negedge clk); cnt_en = 1'b1;
    wait_n(8); cnt_en = 1'b0;
    rd(2, v); chk(v == 16'd2, "R2 prescaled steps", int'(v), 2);
    rd(1, v); chk(v == 16'd0, "R2 prescaler restart", int'(v), 0);
    wait_n(5);
    rd(2, v); chk(v == 16'd2, "R2 hold when disabled", int'(v), 2);

    do_reset();
    wr(3, 3); wr(7, 5); wr(4, 0); wr(5, 9); wr(6, 3); wr(8, 7);
    @(negedge clk); cnt_en = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k >= 8) chk(mat_out[0] == 1'b1, "R6 zero compare stays high", int'(mat_out[0]), 1);
      chk(mat_out[1] == 1'b0, "R7 compare above cycle stays low", int'(mat_out[1]), 0);
    end
    cnt_en = 1'b0;
    wr(10, 16'h0010);
    @(negedge clk); cap_in[0] = 1'b1;
    wait_n(4);
    chk(mat_out == 3'd0, "R12 capture clear drops outputs", int'(mat_out), 0);
    rd(2, v); chk(v == 16'd0, "R9 counter cleared", int'(v), 0);

    for (int code = 0; code < 4; code++) begin
      logic [1:0] bitsel;
      logic       fallsel;
      do_reset();
      bitsel = 2'(code >> 1);
      fallsel = code[0];
      @(negedge clk); cap_in = fallsel ? 2'b11 : 2'b00;
      wait_n(4);
      wr(2, 100); wr(1, 7);
      cap_in[bitsel[0] ? 0 : 1] = ~cap_in[bitsel[0] ? 0 : 1];
      wr(10, 16'h0010 | (code << 5));
      wait_n(4);
      rd(2, v); chk(v == 16'd100, "R9 other input ignored", int'(v), 100);
      cap_in[bitsel[0]] = ~cap_in[bitsel[0]];
      wait_n(4);
      rd(2, v); chk(v == 16'd0, "R9 selected edge clears counter", int'(v), 0);
      rd(1, v); chk(v == 16'd0, "R9 selected edge clears prescaler", int'(v), 0);
    end

    for (int code = 3; code < 8; code++) begin
      do_reset();
      wr(2, 100);
      wr(10, (code == 3) ? (0 << 5) : (16'h0010 | (code << 5)));
      for (int t = 0; t < 4; t++) begin
        @(negedge clk); cap_in = 2'(t + 1);
        wait_n(4);
      end
      @(negedge clk); cap_in = 2'b00;
      wait_n(4);
      rd(2, v); chk(v == 16'd100, "R10 no clear", int'(v), 100);
    end

    for (int cfg = 0; cfg < 24; cfg++) begin
      do_reset();
      pr_c   = 16'($urandom_range(0, 2));
      psel_c = 2'($urandom_range(0, 3));
      pen_c  = 3'($urandom_range(0, 7));
      ext_c  = 3'($urandom_range(0, 7));
      for (int i = 0; i < 4; i++) mm[i] = 16'($urandom_range(0, 18));
      if (mm[psel_c] == 16'd0) mm[psel_c] = 16'($urandom_range(1, 15));
      wr(0, pr_c); wr(3, psel_c); wr(8, pen_c); wr(9, ext_c);
      for (int i = 0; i < 4; i++) wr(4 + i, mm[i]);
      @(negedge clk); model_on = 1'b1;
      for (int k = 0; k < 150; k++) begin
        @(negedge clk);
        chk(mat_out == exp_out(pen_c, pq_m, ext_c), "R3 R4 R5 R8 random outputs",
            int'(mat_out), int'(exp_out(pen_c, pq_m, ext_c)));
        cnt_en = ($urandom_range(0, 3) != 0);
      end
      cnt_en = 1'b0;
      @(negedge clk);
      rd(2, v); chk(v == tc_m, "R3 counter value", int'(v), int'(tc_m));
      model_on = 1'b0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule